// File: doc/BRIEF.md
# DDS Frequency Source Arbiter

This block decides which tuning word feeds the phase accumulator of a direct digital synthesizer, and in the same way which phase offset and amplitude scale reach the later datapath. There are four candidate sources, listed here from highest to lowest priority: a waveform RAM word, a digital ramp generator word, a parallel data port word, and the register set of the active single-tone profile. The parallel word is shifted left by a programmable amount and added to an offset word.

Each modulation source has an enable and a two-bit destination field. A source overrides a parameter only when it is enabled and its destination names that parameter. In every other case the parameter comes from the profile picked by the 3-bit select input. Eight profile register sets sit inside the block, and they are loaded through a simple write port. All three results are registered. A change on any input shows at the outputs one clock after it is applied.

Top module: `dds_src_arb`

## Requirements
- R1: While rst_n is low, ftw_o, pow_o, asf_o and all eight profile register sets are zero.
- R2: When ram_en=1 and ram_dst=0 (frequency), ftw_o equals ram_word one clock later, whatever the other sources do.
- R3: When two or more sources are enabled for the same parameter, the source with the highest priority wins. The order from highest to lowest is RAM, ramp, parallel.
- R4: When RAM is not enabled for frequency and ramp_en=1 with ramp_dst=0, ftw_o equals ramp_word. This holds even when the parallel port is also enabled for frequency.
- R5: When the parallel port is the selected frequency source, ftw_o = (par_offset + (par_word << par_shift)) mod 2^32, with par_shift in the range 0 to 15.
- R6: A source that is enabled with a destination other than frequency (1 phase, 2 amplitude, 3 polar) does not affect ftw_o. ftw_o then equals the FTW of the selected profile.
- R7: With no source enabled, ftw_o, pow_o and asf_o equal the FTW, POW and ASF of the profile selected by prof_sel.
- R8: A cycle with prof_we=1 writes all three fields of profile prof_waddr. The other seven profiles keep their values.
- R9: Phase priority: RAM with destination 1 gives ram_word[31:16], and RAM with destination 3 also gives ram_word[31:16]. Ramp with destination 1 gives ramp_word[31:16]. Parallel with destination 1 gives par_word, and parallel with destination 3 gives {par_word[15:8],8'h00}. The profile POW is used otherwise.
- R10: Amplitude priority: RAM with destination 2 gives ram_word[31:18], and RAM with destination 3 gives ram_word[15:2]. Ramp with destination 2 gives ramp_word[31:18]. Parallel with destination 2 gives par_word[15:2], and parallel with destination 3 gives {par_word[7:0],6'h00}. The profile ASF is used otherwise. A ramp with destination 3 has no target.
- R11: The outputs are registered. A change of prof_sel or of an enable is not visible before the next rising clock edge and is visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_sel | input | 3 | Active profile index |
| prof_we | input | 1 | Profile write strobe |
| prof_waddr | input | 3 | Profile to write |
| prof_wftw | input | 32 | FTW write data |
| prof_wpow | input | 16 | POW write data |
| prof_wasf | input | 14 | ASF write data |
| ram_en | input | 1 | RAM source enable |
| ram_dst | input | 2 | RAM destination (0 freq, 1 phase, 2 ampl, 3 polar) |
| ram_word | input | 32 | RAM output word |
| ramp_en | input | 1 | Ramp source enable |
| ramp_dst | input | 2 | Ramp destination |
| ramp_word | input | 32 | Ramp output word |
| par_en | input | 1 | Parallel port enable |
| par_dst | input | 2 | Parallel destination |
| par_word | input | 16 | Parallel data |
| par_shift | input | 4 | Parallel left shift amount |
| par_offset | input | 32 | Parallel frequency offset word |
| ftw_o | output | 32 | Selected tuning word |
| pow_o | output | 16 | Selected phase offset |
| asf_o | output | 14 | Selected amplitude scale |

## Verification
A profile write and a profile switch can fall in the same cycle. A source can also win the frequency while a different source wins the phase or the amplitude. The bench provokes both. It rewrites one profile while that profile is selected, and it checks that the new values appear two edges later and that a neighbouring profile keeps its values. It also enables RAM for phase or polar while the ramp or parallel port holds frequency, and it checks all three outputs against values computed by hand from the priority rules.

// File: rtl/dds_arb_pkg.sv
package dds_arb_pkg;
  typedef enum logic [1:0] {
    DST_FREQ  = 2'd0,
    DST_PHASE = 2'd1,
    DST_AMPL  = 2'd2,
    DST_POLAR = 2'd3
  } dst_e;
endpackage

// File: rtl/dds_prof_bank.sv
module dds_prof_bank #(
  parameter int NPROF = 8,
  parameter int FTW_W = 32,
  parameter int POW_W = 16,
  parameter int ASF_W = 14,
  localparam int IDX_W = $clog2(NPROF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [FTW_W-1:0] wftw,
  input  logic [POW_W-1:0] wpow,
  input  logic [ASF_W-1:0] wasf,
  input  logic [IDX_W-1:0] rsel,
  output logic [FTW_W-1:0] rftw,
  output logic [POW_W-1:0] rpow,
  output logic [ASF_W-1:0] rasf
);
  logic [FTW_W-1:0] ftw_q [NPROF];
  logic [POW_W-1:0] pow_q [NPROF];
  logic [ASF_W-1:0] asf_q [NPROF];

  for (genvar i = 0; i < NPROF; i++) begin : g_row
    logic row_ce;
    assign row_ce = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ftw_q[i] <= '0;
        pow_q[i] <= '0;
        asf_q[i] <= '0;
      end else if (row_ce) begin
        ftw_q[i] <= wftw;
        pow_q[i] <= wpow;
        asf_q[i] <= wasf;
      end
    end
    // R8: a row not addressed by a write keeps its contents
    a_r8_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == IDX_W'(i)) |=> $stable(ftw_q[i]) && $stable(pow_q[i]) && $stable(asf_q[i]));
  end

  assign rftw = ftw_q[rsel];
  assign rpow = pow_q[rsel];
  assign rasf = asf_q[rsel];
endmodule

// File: rtl/dds_par_fm.sv
module dds_par_fm #(
  parameter int FTW_W   = 32,
  parameter int PAR_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic [PAR_W-1:0]   word,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [FTW_W-1:0]   offset,
  output logic [FTW_W-1:0]   ftw
);
  logic [FTW_W-1:0] scaled;
  always_comb begin
    scaled = FTW_W'(word) << shift;
    ftw    = offset + scaled;
  end
endmodule

// File: rtl/dds_prio_mux.sv
module dds_prio_mux #(
  parameter int W = 32
) (
  input  logic         take_ram,
  input  logic         take_ramp,
  input  logic         take_par,
  input  logic [W-1:0] v_ram,
  input  logic [W-1:0] v_ramp,
  input  logic [W-1:0] v_par,
  input  logic [W-1:0] v_prof,
  output logic [W-1:0] v
);
  always_comb begin
    if (take_ram)       v = v_ram;
    else if (take_ramp) v = v_ramp;
    else if (take_par)  v = v_par;
    else                v = v_prof;
  end
endmodule

// File: rtl/dds_src_arb.sv
module dds_src_arb
  import dds_arb_pkg::*;
#(
  parameter int NPROF   = 8,
  parameter int FTW_W   = 32,
  parameter int POW_W   = 16,
  parameter int ASF_W   = 14,
  parameter int PAR_W   = 16,
  parameter int SHIFT_W = 4,
  localparam int IDX_W  = $clog2(NPROF),
  localparam int HALF   = PAR_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   prof_sel,
  input  logic               prof_we,
  input  logic [IDX_W-1:0]   prof_waddr,
  input  logic [FTW_W-1:0]   prof_wftw,
  input  logic [POW_W-1:0]   prof_wpow,
  input  logic [ASF_W-1:0]   prof_wasf,
  input  logic               ram_en,
  input  logic [1:0]         ram_dst,
  input  logic [FTW_W-1:0]   ram_word,
  input  logic               ramp_en,
  input  logic [1:0]         ramp_dst,
  input  logic [FTW_W-1:0]   ramp_word,
  input  logic               par_en,
  input  logic [1:0]         par_dst,
  input  logic [PAR_W-1:0]   par_word,
  input  logic [SHIFT_W-1:0] par_shift,
  input  logic [FTW_W-1:0]   par_offset,
  output logic [FTW_W-1:0]   ftw_o,
  output logic [POW_W-1:0]   pow_o,
  output logic [ASF_W-1:0]   asf_o
);
  logic [FTW_W-1:0] p_ftw, par_ftw, ftw_d, ftw_q;
  logic [POW_W-1:0] p_pow, ram_pow, par_pow, pow_d, pow_q;
  logic [ASF_W-1:0] p_asf, ram_asf, par_asf, asf_d, asf_q;
  logic f_ram, f_ramp, f_par;
  logic ph_ram, ph_ramp, ph_par;
  logic am_ram, am_ramp, am_par;

  dds_prof_bank #(.NPROF(NPROF), .FTW_W(FTW_W), .POW_W(POW_W), .ASF_W(ASF_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(prof_we), .waddr(prof_waddr),
    .wftw(prof_wftw), .wpow(prof_wpow), .wasf(prof_wasf),
    .rsel(prof_sel), .rftw(p_ftw), .rpow(p_pow), .rasf(p_asf));

  dds_par_fm #(.FTW_W(FTW_W), .PAR_W(PAR_W), .SHIFT_W(SHIFT_W)) u_par (
    .word(par_word), .shift(par_shift), .offset(par_offset), .ftw(par_ftw));

  // destination decode per parameter
  always_comb begin
    f_ram   = ram_en  && (ram_dst  == DST_FREQ);
    f_ramp  = ramp_en && (ramp_dst == DST_FREQ);
    f_par   = par_en  && (par_dst  == DST_FREQ);
    ph_ram  = ram_en  && (ram_dst  == DST_PHASE || ram_dst == DST_POLAR);
    ph_ramp = ramp_en && (ramp_dst == DST_PHASE);
    ph_par  = par_en  && (par_dst  == DST_PHASE || par_dst == DST_POLAR);
    am_ram  = ram_en  && (ram_dst  == DST_AMPL  || ram_dst == DST_POLAR);
    am_ramp = ramp_en && (ramp_dst == DST_AMPL);
    am_par  = par_en  && (par_dst  == DST_AMPL  || par_dst == DST_POLAR);
  end

  // field extraction from the source words
  always_comb begin
    ram_pow = ram_word[FTW_W-1 -: POW_W];
    ram_asf = (ram_dst == DST_POLAR) ? ram_word[FTW_W-POW_W-1 -: ASF_W]
                                     : ram_word[FTW_W-1 -: ASF_W];
    if (par_dst == DST_POLAR) begin
      par_pow = {par_word[PAR_W-1 -: HALF], {(POW_W-HALF){1'b0}}};
      par_asf = {par_word[HALF-1:0], {(ASF_W-HALF){1'b0}}};
    end else begin
      par_pow = POW_W'(par_word);
      par_asf = par_word[PAR_W-1 -: ASF_W];
    end
  end

  dds_prio_mux #(.W(FTW_W)) u_fsel (
    .take_ram(f_ram), .take_ramp(f_ramp), .take_par(f_par),
    .v_ram(ram_word), .v_ramp(ramp_word), .v_par(par_ftw), .v_prof(p_ftw), .v(ftw_d));

  dds_prio_mux #(.W(POW_W)) u_psel (
    .take_ram(ph_ram), .take_ramp(ph_ramp), .take_par(ph_par),
    .v_ram(ram_pow), .v_ramp(ramp_word[FTW_W-1 -: POW_W]), .v_par(par_pow), .v_prof(p_pow), .v(pow_d));

  dds_prio_mux #(.W(ASF_W)) u_asel (
    .take_ram(am_ram), .take_ramp(am_ramp), .take_par(am_par),
    .v_ram(ram_asf), .v_ramp(ramp_word[FTW_W-1 -: ASF_W]), .v_par(par_asf), .v_prof(p_asf), .v(asf_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q <= '0;
      pow_q <= '0;
      asf_q <= '0;
    end else begin
      ftw_q <= ftw_d;
      pow_q <= pow_d;
      asf_q <= asf_d;
    end
  end

  assign ftw_o = ftw_q;
  assign pow_o = pow_q;
  assign asf_o = asf_q;

  // R2: RAM with frequency destination always drives the tuning word
  a_r2_ram_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_dst == 2'd0) |=> ftw_o == $past(ram_word));
  // R4: ramp wins frequency when RAM does not claim it
  a_r4_ramp_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ram_en && ram_dst == 2'd0) && ramp_en && ramp_dst == 2'd0) |=> ftw_o == $past(ramp_word));
  // R5: parallel frequency is offset plus shifted word
  a_r5_par_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ram_en && ram_dst == 2'd0) && !(ramp_en && ramp_dst == 2'd0) && par_en && par_dst == 2'd0)
    |=> ftw_o == $past(par_offset + (FTW_W'(par_word) << par_shift)));
  // R7: idle sources leave the profile values on the outputs
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_en && !ramp_en && !par_en) |=> (ftw_o == $past(p_ftw) && pow_o == $past(p_pow) && asf_o == $past(p_asf)));
  // R9: RAM phase destination drives the phase word
  a_r9_ram_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_dst == 2'd1) |=> pow_o == $past(ram_word[FTW_W-1 -: POW_W]));
  // R10: ramp amplitude destination drives the amplitude when RAM does not
  a_r10_ramp_ampl: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ram_en && ram_dst[1]) && ramp_en && ramp_dst == 2'd2) |=> asf_o == $past(ramp_word[FTW_W-1 -: ASF_W]));
endmodule

// File: tb/dds_src_arb_tb.sv
module dds_src_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  prof_sel, prof_waddr;
  logic        prof_we;
  logic [31:0] prof_wftw;
  logic [15:0] prof_wpow;
  logic [13:0] prof_wasf;
  logic        ram_en, ramp_en, par_en;
  logic [1:0]  ram_dst, ramp_dst, par_dst;
  logic [31:0] ram_word, ramp_word, par_offset;
  logic [15:0] par_word;
  logic [3:0]  par_shift;
  logic [31:0] ftw_o;
  logic [15:0] pow_o;
  logic [13:0] asf_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_ftw [8];
  logic [15:0] m_pow [8];
  logic [13:0] m_asf [8];

  always #2 clk = ~clk;

  dds_src_arb dut_i (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .prof_we(prof_we),
    .prof_waddr(prof_waddr), .prof_wftw(prof_wftw), .prof_wpow(prof_wpow),
    .prof_wasf(prof_wasf), .ram_en(ram_en), .ram_dst(ram_dst), .ram_word(ram_word),
    .ramp_en(ramp_en), .ramp_dst(ramp_dst), .ramp_word(ramp_word),
    .par_en(par_en), .par_dst(par_dst), .par_word(par_word), .par_shift(par_shift),
    .par_offset(par_offset), .ftw_o(ftw_o), .pow_o(pow_o), .asf_o(asf_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_src();
    ram_en = 0; ramp_en = 0; par_en = 0;
    ram_dst = 0; ramp_dst = 0; par_dst = 0;
  endtask

  task automatic wr(input int p, input logic [31:0] f, input logic [15:0] ph, input logic [13:0] a);
    prof_we = 1; prof_waddr = 3'(p); prof_wftw = f; prof_wpow = ph; prof_wasf = a;
    tick();
    prof_we = 0;
    m_ftw[p] = f; m_pow[p] = ph; m_asf[p] = a;
  endtask

  task automatic t_reset();
    rst_n = 0;
    #1;
    chk("R1 ftw", ftw_o, 0);
    chk("R1 pow", 32'(pow_o), 0);
    chk("R1 asf", 32'(asf_o), 0);
    tick(); tick();
    rst_n = 1;
    tick();
    prof_sel = 3'd6;
    tick();
    chk("R1 profile6 ftw zero", ftw_o, 0);
  endtask

  task automatic t_profiles();
    for (int p = 0; p < 8; p++)
      wr(p, 32'h1000_0000 + 32'(p) * 32'h0101_0101, 16'(16'h1000 * p + 3), 14'(14'h0100 * p + 1));
    for (int p = 7; p >= 0; p--) begin
      prof_sel = 3'(p);
      tick();
      chk("R7 ftw", ftw_o, m_ftw[p]);
      chk("R7 pow", 32'(pow_o), 32'(m_pow[p]));
      chk("R7 asf", 32'(asf_o), 32'(m_asf[p]));
    end
    prof_sel = 3'd3;
    wr(3, 32'hDEAD_BEEF, 16'hCAFE, 14'h2AAA);
    tick();
    chk("R8 written ftw", ftw_o, 32'hDEAD_BEEF);
    chk("R8 written asf", 32'(asf_o), 32'h2AAA);
    prof_sel = 3'd2;
    tick();
    chk("R8 neighbour ftw", ftw_o, m_ftw[2]);
    prof_sel = 3'd4;
    tick();
    chk("R8 neighbour pow", 32'(pow_o), 32'(m_pow[4]));
  endtask

  task automatic t_latency();
    prof_sel = 3'd1;
    tick();
    prof_sel = 3'd5;
    #1;
    chk("R11 before edge", ftw_o, m_ftw[1]);
    tick();
    chk("R11 after edge", ftw_o, m_ftw[5]);
    ram_en = 1; ram_dst = 0; ram_word = 32'h0BAD_F00D;
    #1;
    chk("R11 enable before edge", ftw_o, m_ftw[5]);
    tick();
    chk("R11 enable after edge", ftw_o, 32'h0BAD_F00D);
    idle_src();
    tick();
  endtask

  task automatic t_priority();
    ram_word = 32'hAAAA_5555; ramp_word = 32'h1357_9BDF;
    par_word = 16'h1234; par_shift = 0; par_offset = 32'h0100_0000;
    ram_en = 1; ramp_en = 1; par_en = 1;
    tick();
    chk("R2 ram freq", ftw_o, 32'hAAAA_5555);
    chk("R3 ram over ramp/par", ftw_o, 32'hAAAA_5555);
    ram_dst = 2'd1;
    tick();
    chk("R4 ramp freq", ftw_o, 32'h1357_9BDF);
    chk("R9 ram phase", 32'(pow_o), 32'hAAAA);
    ramp_en = 0;
    tick();
    chk("R3 par after ramp off", ftw_o, 32'h0100_1234);
    idle_src();
    tick();
  endtask

  task automatic t_parallel();
    par_en = 1; par_dst = 0; par_offset = 32'h0100_0000; par_word = 16'h1234;
    par_shift = 4'd4;
    tick();
    chk("R5 shift4", ftw_o, 32'h0101_2340);
    par_shift = 4'd15; par_word = 16'h8001; par_offset = 32'hFFFF_0000;
    tick();
    chk("R5 shift15 wrap", ftw_o, 32'h3FFF_8000);
    par_shift = 4'd0; par_word = 16'hFFFF; par_offset = 32'hFFFF_FFF0;
    tick();
    chk("R5 shift0 wrap", ftw_o, 32'h0000_FFEF);
    idle_src();
    tick();
  endtask

  task automatic t_other_dst();
    prof_sel = 3'd6;
    ram_en = 1; ram_dst = 2'd3; ramp_en = 1; ramp_dst = 2'd2; par_en = 1; par_dst = 2'd1;
    ram_word = 32'h1234_5678; ramp_word = 32'hFFFF_FFFF; par_word = 16'h4321;
    tick();
    chk("R6 no freq source", ftw_o, m_ftw[6]);
    chk("R9 ram polar phase", 32'(pow_o), 32'h1234);
    chk("R10 ram polar ampl", 32'(asf_o), 32'h159E);
    ram_en = 0;
    tick();
    chk("R10 ramp ampl", 32'(asf_o), 32'h3FFF);
    chk("R9 par phase", 32'(pow_o), 32'h4321);
    ramp_en = 0; par_dst = 2'd3;
    tick();
    chk("R9 par polar phase", 32'(pow_o), 32'h4300);
    chk("R10 par polar ampl", 32'(asf_o), 32'h0840);
    par_dst = 2'd2;
    tick();
    chk("R10 par ampl", 32'(asf_o), 32'h10C8);
    par_en = 0; ramp_en = 1; ramp_dst = 2'd3;
    tick();
    chk("R10 ramp polar no target asf", 32'(asf_o), 32'(m_asf[6]));
    chk("R9 ramp polar no target pow", 32'(pow_o), 32'(m_pow[6]));
    idle_src();
    tick();
  endtask

  initial begin
    rst_n = 0; prof_sel = 0; prof_we = 0; prof_waddr = 0;
    prof_wftw = 0; prof_wpow = 0; prof_wasf = 0;
    ram_word = 0; ramp_word = 0; par_word = 0; par_shift = 0; par_offset = 0;
    idle_src();
    t_reset();
    t_profiles();
    t_latency();
    t_priority();
    t_parallel();
    t_other_dst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule